// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. Each frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. The line idles high. The block samples the line only on cycles where an external oversample tick is high, and that tick runs at eight times the baud rate (for example 921.6 kHz for 115200 baud). The serial input first goes through a two-flop synchronizer. A two-bit saturating up/down counter then filters it, so that a low spike of one or two samples on an idle line never starts a frame.

A small state machine walks through the frame. Its states are `ST_IDLE` (waiting for a filtered low), `ST_DATA` (collecting the eight data bits) and `ST_STOP` (checking the stop bit). The transitions are:

- idle→data when the filtered bit is 0 on a tick.
- data→data on each bit strobe until the eighth bit.
- data→stop on the strobe that takes the eighth bit.
- stop→idle on the next strobe.
- Any unused state code goes to idle.

A three-bit spacing counter is held at zero in idle and advances on every tick otherwise. Its terminal value of 7 forms the bit strobe. Each data bit is shifted into the top of a right-shifting register. A good stop bit gives a one-clock `byte_valid` pulse. A low stop bit gives a one-clock `frame_err` pulse instead.

Top module: `serial_byte_receiver`

## Requirements
- R1: After reset `byte_valid`, `frame_err` and `rx_byte` are all 0, and a line held high produces no pulse on either output.
- R2: The first data bit received after the start bit appears in `rx_byte[0]` and the eighth in `rx_byte[7]`. `rx_byte` holds the received byte during the `byte_valid` pulse.
- R3: `byte_valid` is high for exactly one clock cycle per frame whose stop sample is 1.
- R4: A stop sample of 0 produces a one-clock `frame_err` pulse and no `byte_valid`. If the line is still low when the machine returns to idle, a new frame starts.
- R5: A low spike lasting one or two oversample ticks on an idle line produces no output, and a frame sent afterwards is received correctly.
- R6: Frames whose bit period is up to 2% shorter, or up to 1% longer, than eight ticks are received correctly. This assumes the start edge arrives just after a tick.
- R7: Frames separated by only one tick of idle after the stop bit are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample strobe, one clock wide, at 8x the baud rate |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rx_byte | output | 8 | Assembled byte, valid during `byte_valid` |
| byte_valid | output | 1 | One-clock pulse on a frame with a good stop bit |
| frame_err | output | 1 | One-clock pulse on a frame whose stop bit sampled low |

## Verification
The embedded assertions cover the properties that hold cycle by cycle:
- The filter counter moves by at most one step and never wraps.
- The filtered bit changes only on tick cycles.
- The bit strobe is silent while the machine idles.
- Each output pulse lasts one clock, the two pulses never coincide, and `rx_byte` is stable when `byte_valid` rises.

Only the bench scenarios can show the rest: that bits land in the right positions for all 256 byte values, that the spike filter rejects short glitches without losing the next frame, and how much baud mismatch the fixed sample point tolerates. The bench also shows the re-arming behaviour after a framing error.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_STOP = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rx_sync_filter.sv
module rx_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_W      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic filt
);
    localparam logic [FILT_W-1:0] CNT_TOP = '1;
    localparam logic [FILT_W-1:0] CNT_BOT = '0;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_W-1:0]      cnt_q;
    logic                   filt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];
    assign filt   = filt_q;

    // synchronizer chain, advanced only on oversample ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else if (tick) begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line};
        end
    end

    // saturating up/down counter with hysteresis on the output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_TOP;
            filt_q <= 1'b1;
        end else if (tick) begin
            if (synced && cnt_q != CNT_TOP) begin
                cnt_q <= cnt_q + FILT_W'(1);
            end else if (!synced && cnt_q != CNT_BOT) begin
                cnt_q <= cnt_q - FILT_W'(1);
            end
            if (cnt_q == CNT_BOT) begin
                filt_q <= 1'b0;
            end else if (cnt_q == CNT_TOP) begin
                filt_q <= 1'b1;
            end
        end
    end

    AST_FILT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + FILT_W'(1)) || (cnt_q == $past(cnt_q) - FILT_W'(1))); // R5
    AST_FILT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(cnt_q) == CNT_TOP && cnt_q == CNT_BOT) || ($past(cnt_q) == CNT_BOT && cnt_q == CNT_TOP))); // R5
    AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt_q)); // R5

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int OVS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    output logic strobe
);
    localparam int SPC_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [SPC_W-1:0] SPC_LAST = SPC_W'(OVS - 1);

    logic [SPC_W-1:0] spc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spc_q <= '0;
        end else if (hold) begin
            spc_q <= '0;
        end else if (tick) begin
            spc_q <= (spc_q == SPC_LAST) ? '0 : spc_q + SPC_W'(1);
        end
    end

    assign strobe = (spc_q == SPC_LAST);

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !strobe); // R6

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              filt,
    input  logic              strobe,
    output logic              idle,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              err
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              valid_q, err_q;
    logic              step;

    assign step  = tick && strobe;
    assign idle  = (state_q == ST_IDLE);
    assign data  = shreg_q;
    assign valid = valid_q;
    assign err   = err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick && !filt)                 state_d = ST_DATA;
            ST_DATA: if (step && idx_q == IDX_LAST)     state_d = ST_STOP;
            ST_STOP: if (step)                          state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            shreg_q <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= step && (state_q == ST_STOP) && filt;
            err_q   <= step && (state_q == ST_STOP) && !filt;
            if (state_q == ST_IDLE) begin
                idx_q <= '0;
            end else if (step && state_q == ST_DATA) begin
                shreg_q <= {filt, shreg_q[DATA_W-1:1]};
                idx_q   <= idx_q + IDX_W'(1);
            end
        end
    end

    AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R3
    AST_ERR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q); // R4
    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_q && err_q)); // R4
    AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $stable(shreg_q)); // R2

endmodule

// File: rtl/serial_byte_receiver.sv
module serial_byte_receiver #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_valid,
    output logic              frame_err
);
    logic filt_bit;
    logic in_idle;
    logic bit_strobe;

    rx_sync_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_W     (FILT_W)
    ) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (os_tick),
        .line (rx_line),
        .filt (filt_bit)
    );

    rx_bit_timer #(
        .OVS(OVS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (os_tick),
        .hold  (in_idle),
        .strobe(bit_strobe)
    );

    rx_frame_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (os_tick),
        .filt  (filt_bit),
        .strobe(bit_strobe),
        .idle  (in_idle),
        .data  (rx_byte),
        .valid (byte_valid),
        .err   (frame_err)
    );

endmodule

// File: tb/serial_byte_receiver_test.sv
`timescale 1ns/100ps
module serial_byte_receiver_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_byte;
    logic       byte_valid;
    logic       frame_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int div     = 0;
    bit done    = 1'b0;

    logic [8:0] ev_log [0:1023];
    logic [8:0] ex_log [0:1023];
    int ev_n = 0;
    int ex_n = 0;
    logic prev_v = 1'b0;
    logic prev_e = 1'b0;

    always #2.5 clk = ~clk;

    serial_byte_receiver uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_line   (rx_line),
        .rx_byte   (rx_byte),
        .byte_valid(byte_valid),
        .frame_err (frame_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // oversample tick: one clock high every four clocks
    always @(negedge clk) begin
        os_tick = (div == 3);
        div = (div == 3) ? 0 : div + 1;
    end

    // output monitor: logs events and checks pulse widths
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v) check(!byte_valid, "R3 byte_valid width", byte_valid, 0);
            if (prev_e) check(!frame_err, "R4 frame_err width", frame_err, 0);
            if (byte_valid && !prev_v && ev_n < 1024) begin
                ev_log[ev_n] = {1'b0, rx_byte};
                ev_n++;
            end
            if (frame_err && !prev_e && ev_n < 1024) begin
                ev_log[ev_n] = 9'h100;
                ev_n++;
            end
            prev_v = byte_valid;
            prev_e = frame_err;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic expect_ev(input logic [8:0] e);
        ex_log[ex_n] = e;
        ex_n++;
    endtask

    task automatic compare(input string req);
        check(ev_n == ex_n, req, ev_n, ex_n);
        for (int i = 0; i < ev_n && i < ex_n; i++)
            check(ev_log[i] == ex_log[i], req, int'(ev_log[i]), int'(ex_log[i]));
        ev_n = 0;
        ex_n = 0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // frame with bit period per_x100/100 clocks; start edge just after a tick
    task automatic send_frame(input logic [7:0] b, input logic stop_v, input int per_x100);
        logic [9:0] bits;
        int pos;
        bits = {stop_v, b, 1'b0};
        do @(posedge clk); while (!os_tick);
        @(negedge clk);
        rx_line = bits[0];
        pos = 0;
        for (int k = 1; k <= 10; k++) begin
            int target;
            target = (k * per_x100 + 50) / 100;
            while (pos < target) begin
                @(negedge clk);
                pos++;
            end
            rx_line = (k < 10) ? bits[k] : 1'b1;
        end
    endtask

    task automatic glitch(input int ticks);
        do @(posedge clk); while (!os_tick);
        @(negedge clk);
        rx_line = 1'b0;
        wait_clk(4 * ticks);
        rx_line = 1'b1;
    endtask

    initial begin
        wait_clk(10);
        // R1: reset values
        check(byte_valid == 1'b0, "R1 byte_valid", byte_valid, 0);
        check(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        check(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
        rst_n = 1'b1;
        wait_clk(200);
        compare("R1 idle line");

        // R2 R7: every byte value, nominal rate, minimal idle between frames
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 1'b1, 3200);
            expect_ev({1'b0, 8'(b)});
        end
        wait_clk(500);
        compare("R2 R7 sweep");

        // R6: line 2% fast
        for (int i = 0; i < 32; i++) begin
            send_frame(8'((i * 37 + 5) & 255), 1'b1, 3136);
            expect_ev({1'b0, 8'((i * 37 + 5) & 255)});
            wait_clk(64);
        end
        wait_clk(500);
        compare("R6 fast line");

        // R6: line 1% slow
        for (int i = 0; i < 32; i++) begin
            send_frame(8'((i * 91 + 200) & 255), 1'b1, 3232);
            expect_ev({1'b0, 8'((i * 91 + 200) & 255)});
            wait_clk(64);
        end
        wait_clk(500);
        compare("R6 slow line");

        // R5: short spikes on idle line produce nothing
        for (int i = 0; i < 12; i++) begin
            glitch((i % 2) + 1);
            wait_clk(120);
        end
        wait_clk(500);
        compare("R5 spikes ignored");
        glitch(2);
        wait_clk(40);
        send_frame(8'h3C, 1'b1, 3200);
        expect_ev({1'b0, 8'h3C});
        wait_clk(500);
        compare("R5 frame after spikes");

        // R4: bad stop bit, then re-armed start on the still-low line gives 0xFF
        send_frame(8'hA5, 1'b0, 3200);
        expect_ev(9'h100);
        expect_ev({1'b0, 8'hFF});
        wait_clk(700);
        compare("R4 framing error");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule